// File: doc/BRIEF.md
# ADC sampling frame controller

This block is the serial master for a two-channel, 12-bit successive-approximation converter. It connects over a four-wire synchronous link: an active-low chip select, a serial clock, a line into the converter and a line back from it. The serial clock comes from the fast system clock through a programmable divider. A sample timer counts whole serial-clock periods, so conversion frames start at evenly spaced instants. Every frame start falls on a falling edge of the serial clock.

A normal frame holds chip select low for sixteen serial periods. During the frame the block sends a channel-select bit to the converter and shifts in the converter's 16-bit word, most significant bit first. When chip select rises, the block presents the 12 result bits with a one-cycle strobe. When the power-down input is set, the next frame is cut to eight periods. This puts the converter to sleep and returns no sample.

The frame state machine has three states. In IDLE, chip select is high and the block waits for a timer request. IDLE goes to SHIFT on a request. In SHIFT, chip select is low and bits move. SHIFT goes to GAP on the falling edge after the last bit. In GAP, chip select is high for at least one full serial period. GAP goes back to SHIFT if a request arrives on the next falling edge, and to IDLE otherwise.

Top module: `adc_frame_master`

## Requirements
- R1: The serial clock period is 2*(div_cfg+1) system clocks. The first half of each period is high and the second half is low. The serial clock rests high whenever chip select is high.
- R2: Chip select falls only on a serial-clock falling edge. With interval setting N, successive frame starts are exactly N+1 serial periods apart, provided N+1 is at least 17.
- R3: An interval_cfg value of zero is ignored and the last nonzero value stays in force. After reset the interval setting is 19, which gives 20 periods.
- R4: A normal frame holds chip select low for exactly 16 serial periods and contains 16 rising serial-clock edges.
- R5: adc_miso is sampled on rising serial-clock edges, most significant bit first. sample_data equals bits [13:2] of the 16 received bits, where bit 15 is the first received.
- R6: sample_valid is high for exactly one clock, the clock in which chip select returns high after a normal frame.
- R7: A frame started while pd_req is 1 holds chip select low for exactly 8 serial periods and produces no sample_valid.
- R8: Chip select stays high for at least one full serial period between frames. A timer request that lands while a frame is running, or on the falling edge that ends it, is dropped.
- R9: adc_mosi changes only on serial-clock falling edges. It carries the chan_sel value latched at frame start during the third serial period of a frame (word bit 13). At all other times it is 0.
- R10: While enable is 0, no new frame starts and the timer restarts from zero. A frame already in progress completes normally.
- R11: During reset, chip select and the serial clock are high, and adc_mosi, sample_valid and sample_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows the sample timer to request frames |
| div_cfg | input | DIV_W | Serial half-period length minus one, in system clocks |
| interval_cfg | input | INTV_W | Frame spacing minus one, in serial periods; zero is ignored |
| pd_req | input | 1 | Makes the next frame a short power-down frame |
| chan_sel | input | 1 | Channel-select bit sent to the converter |
| adc_miso | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select / frame sync |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Serial data to the converter |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| sample_data | output | RES_BITS | Latest conversion result |

## Verification
A wrong divider count or phase shows up on adc_sclk within one serial half-period. A timer that drifts or skips a count moves the next chip-select fall, so a per-clock model catches it by the following frame start. A bit counter that is off by one changes the chip-select low width and shifts the channel bit on adc_mosi in the same frame. A capture on the wrong edge, or a wrong slice of the word, corrupts sample_data at the very next strobe. The bench checks that value against the word its own converter model sent.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } frame_state_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             phase_hi_o,
    output logic             fall_tick_o,
    output logic             rise_tick_o
);

    logic [DIV_W-1:0] half_cnt_q;
    logic             phase_q;
    logic             half_done;

    assign half_done = (half_cnt_q >= div_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt_q <= '0;
            phase_q    <= 1'b1;
        end else if (half_done) begin
            half_cnt_q <= '0;
            phase_q    <= ~phase_q;
        end else begin
            half_cnt_q <= half_cnt_q + 1'b1;
        end
    end

    assign phase_hi_o  = phase_q;
    assign fall_tick_o = half_done & phase_q;
    assign rise_tick_o = half_done & ~phase_q;

    // R1
    fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick_o |=> !fall_tick_o);

endmodule

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
    parameter int INTV_W   = 16,
    parameter int INTV_RST = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INTV_W-1:0] interval_cfg,
    input  logic              fall_tick,
    output logic              fire_o
);

    logic [INTV_W-1:0] interval_q;
    logic [INTV_W-1:0] period_cnt_q;
    logic              reached;

    assign reached = (period_cnt_q >= interval_q);
    assign fire_o  = enable & fall_tick & reached;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval_q <= INTV_W'(INTV_RST);
        end else if (interval_cfg != '0) begin
            interval_q <= interval_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_cnt_q <= '0;
        end else if (!enable) begin
            period_cnt_q <= '0;
        end else if (fall_tick) begin
            period_cnt_q <= reached ? '0 : period_cnt_q + 1'b1;
        end
    end

    // R3
    interval_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interval_q != '0);

endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
    import adc_frame_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int INTV_W     = 16,
    parameter int INTV_RST   = 19,
    parameter int FRAME_BITS = 16,
    parameter int PD_BITS    = 8,
    parameter int RES_BITS   = 12,
    parameter int RES_LSB    = 2,
    parameter int CHAN_POS   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [DIV_W-1:0]    div_cfg,
    input  logic [INTV_W-1:0]   interval_cfg,
    input  logic                pd_req,
    input  logic                chan_sel,
    input  logic                adc_miso,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                adc_mosi,
    output logic                sample_valid,
    output logic [RES_BITS-1:0] sample_data
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int RX_W  = FRAME_BITS;

    logic phase_hi, fall_tick, rise_tick, fire;

    adc_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_cfg     (div_cfg),
        .phase_hi_o  (phase_hi),
        .fall_tick_o (fall_tick),
        .rise_tick_o (rise_tick)
    );

    adc_interval_timer #(.INTV_W(INTV_W), .INTV_RST(INTV_RST)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .interval_cfg (interval_cfg),
        .fall_tick    (fall_tick),
        .fire_o       (fire)
    );

    frame_state_t      state_q, state_d;
    logic [CNT_W-1:0]  bits_q, len_q;
    logic              pd_q, chan_q, cs_q, mosi_q, valid_q;
    logic [RX_W-1:0]   rx_q;
    logic [RES_BITS-1:0] data_q;
    logic              start, finish;

    assign start  = fire && (state_q == ST_IDLE || state_q == ST_GAP);
    assign finish = (state_q == ST_SHIFT) && fall_tick && (bits_q == len_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fire) state_d = ST_SHIFT;
            ST_SHIFT: if (finish) state_d = ST_GAP;
            ST_GAP:   if (fall_tick) state_d = fire ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            mosi_q  <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
            bits_q  <= '0;
            len_q   <= '0;
            pd_q    <= 1'b0;
            chan_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                cs_q   <= 1'b0;
                bits_q <= '0;
                len_q  <= pd_req ? CNT_W'(PD_BITS) : CNT_W'(FRAME_BITS);
                pd_q   <= pd_req;
                chan_q <= chan_sel;
                mosi_q <= (CHAN_POS == 0) ? chan_sel : 1'b0;
            end else if (finish) begin
                cs_q   <= 1'b1;
                mosi_q <= 1'b0;
                if (!pd_q) begin
                    valid_q <= 1'b1;
                    data_q  <= rx_q[RES_LSB +: RES_BITS];
                end
            end else if (state_q == ST_SHIFT) begin
                if (rise_tick) begin
                    rx_q   <= {rx_q[RX_W-2:0], adc_miso};
                    bits_q <= bits_q + 1'b1;
                end
                if (fall_tick) begin
                    mosi_q <= (bits_q == CNT_W'(CHAN_POS)) ? chan_q : 1'b0;
                end
            end
        end
    end

    assign adc_cs_n     = cs_q;
    assign adc_sclk     = cs_q ? 1'b1 : phase_hi;
    assign adc_mosi     = mosi_q;
    assign sample_valid = valid_q;
    assign sample_data  = data_q;

    // R2
    cs_fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(fall_tick));

    // R6
    valid_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $rose(adc_cs_n));

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |=> adc_cs_n);

    // R4
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (bits_q <= len_q));

endmodule

// File: tb/tb_adc_frame_master.sv
module tb_adc_frame_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  div_cfg = 8'd3;
    logic [15:0] interval_cfg = 16'd0;
    logic        pd_req = 1'b0;
    logic        chan_sel = 1'b0;
    logic        adc_miso = 1'b0;
    logic        adc_cs_n, adc_sclk, adc_mosi, sample_valid;
    logic [11:0] sample_data;

    always #10 clk = ~clk;

    adc_frame_master dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
        .interval_cfg(interval_cfg), .pd_req(pd_req), .chan_sel(chan_sel),
        .adc_miso(adc_miso), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_mosi(adc_mosi), .sample_valid(sample_valid), .sample_data(sample_data)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit chk_en = 0, done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // converter model: launches a fresh word at each frame start
    logic [15:0] adc_word = '0;
    int          adc_idx = 0;
    always @(negedge adc_cs_n) begin
        adc_word = {2'b00, 12'($urandom), 2'b00};
        adc_idx  = 15;
        adc_miso = adc_word[15];
    end
    always @(posedge adc_sclk) begin
        if (!adc_cs_n && adc_idx > 0) begin
            adc_idx  = adc_idx - 1;
            adc_miso = adc_word[adc_idx];
        end
    end

    // behavioural reference, advanced on every rising clock
    int H = 4, k = 0, tm = 0, mi = 19, st = 0, nb = 0, len = 16;
    bit pdl = 0, chl = 0, e_cs = 1, e_mosi = 0, e_valid = 0, e_sclk = 1;
    int e_data = 0;
    logic [15:0] m_rx = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            k = 0; tm = 0; mi = 19; st = 0; nb = 0; e_cs = 1; e_mosi = 0;
            e_valid = 0; e_data = 0; m_rx = '0; e_sclk = 1;
        end else begin
            bit fall, rise, fire;
            k++;
            fall = (k % (2 * H)) == H;
            rise = (k % (2 * H)) == 0;
            fire = enable && fall && (tm >= mi);
            if (!enable) tm = 0;
            else if (fall) tm = (tm >= mi) ? 0 : tm + 1;
            if (interval_cfg != 0) mi = interval_cfg;
            e_valid = 0;
            if ((st == 0 || (st == 2 && fall)) && fire) begin
                st = 1; e_cs = 0; nb = 0; len = pd_req ? 8 : 16;
                pdl = pd_req; chl = chan_sel; e_mosi = 0;
            end else if (st == 2 && fall) begin
                st = 0;
            end else if (st == 1) begin
                if (rise) begin m_rx = {m_rx[14:0], adc_miso}; nb++; end
                if (fall) begin
                    if (nb == len) begin
                        st = 2; e_cs = 1; e_mosi = 0;
                        if (!pdl) begin e_valid = 1; e_data = m_rx[13:2]; end
                    end else begin
                        e_mosi = (nb == 2) ? chl : 1'b0;
                    end
                end
            end
            e_sclk = e_cs ? 1'b1 : (((k / H) % 2) == 0);
        end
    end

    // per-clock comparison and frame measurements
    int nfr = 0, nval = 0, last_fall = 0, spacing = 0, low_w = 0, mhi = 0, last_mhi = 0;
    bit prev_cs = 1;
    always @(negedge clk) begin
        if (chk_en) begin
            check(adc_cs_n === e_cs, "R4 chip select", adc_cs_n, e_cs);
            check(adc_sclk === e_sclk, "R1 serial clock", adc_sclk, e_sclk);
            check(adc_mosi === e_mosi, "R9 data to converter", adc_mosi, e_mosi);
            check(sample_valid === e_valid, "R6 valid strobe", sample_valid, e_valid);
            if (e_valid) begin
                check(sample_data === 12'(e_data), "R5 result vs model", sample_data, e_data);
                check(sample_data === adc_word[13:2], "R5 result vs sent word",
                      sample_data, adc_word[13:2]);
            end
            if (sample_valid) nval++;
            if (!adc_cs_n && adc_mosi) mhi++;
            if (prev_cs && !adc_cs_n) begin
                spacing = cyc - last_fall; last_fall = cyc; nfr++; mhi = 0;
            end
            if (!prev_cs && adc_cs_n) begin
                low_w = cyc - last_fall; last_mhi = mhi;
            end
            prev_cs = adc_cs_n;
        end
    end

    task automatic wait_frames(input int n);
        int target = nfr + n;
        int cnt = 0;
        while (nfr < target && cnt < 20000) begin @(negedge clk); cnt++; end
        if (cnt >= 20000) check(0, "watchdog waiting for frames", nfr, target);
    endtask

    task automatic wait_cs_high();
        int cnt = 0;
        while (adc_cs_n !== 1'b1 && cnt < 5000) begin @(negedge clk); cnt++; end
        if (cnt >= 5000) check(0, "watchdog waiting for cs high", 0, 1);
    endtask

    task automatic do_reset(input int div);
        @(negedge clk);
        chk_en = 0; rst_n = 0; div_cfg = 8'(div); H = div + 1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(adc_cs_n === 1'b1, "R11 cs in reset", adc_cs_n, 1);
        check(adc_sclk === 1'b1, "R11 sclk in reset", adc_sclk, 1);
        check(adc_mosi === 1'b0, "R11 mosi in reset", adc_mosi, 0);
        check(sample_valid === 1'b0, "R11 valid in reset", sample_valid, 0);
        check(sample_data === 12'd0, "R11 data in reset", sample_data, 0);
        rst_n = 1; prev_cs = 1; last_fall = cyc; chk_en = 1;
    endtask

    initial begin
        int n0;
        do_reset(3);
        enable = 1; interval_cfg = 0;
        wait_frames(3);
        check(spacing == 160, "R3 reset interval spacing", spacing, 160);
        check(low_w == 128, "R4 frame width", low_w, 128);

        interval_cfg = 24; chan_sel = 1;
        wait_frames(3);
        check(spacing == 200, "R2 interval spacing", spacing, 200);
        check(last_mhi == 8, "R9 channel bit span", last_mhi, 8);
        interval_cfg = 0;
        wait_frames(3);
        check(spacing == 200, "R3 zero interval ignored", spacing, 200);

        interval_cfg = 16;
        wait_frames(3);
        check(spacing == 136, "R8 minimum spacing", spacing, 136);
        check(spacing - low_w == 8, "R8 one period high gap", spacing - low_w, 8);
        interval_cfg = 10;
        wait_frames(3);
        check(spacing == 176, "R8 dropped request", spacing, 176);

        interval_cfg = 20; pd_req = 1;
        wait_frames(1);
        n0 = nval;
        wait_frames(2);
        wait_cs_high();
        check(low_w == 64, "R7 power-down width", low_w, 64);
        check(nval == n0, "R7 no valid in power-down", nval, n0);

        pd_req = 0; chan_sel = 0;
        do_reset(0);
        enable = 1; interval_cfg = 20; chan_sel = 1;
        wait_frames(3);
        check(spacing == 42, "R1 fastest divider spacing", spacing, 42);
        wait_cs_high();
        check(low_w == 32, "R4 fastest divider width", low_w, 32);

        wait_frames(1);
        enable = 0;
        wait_cs_high();
        check(low_w == 32, "R10 frame completes after disable", low_w, 32);
        n0 = nfr;
        repeat (300) @(negedge clk);
        check(nfr == n0, "R10 no frames while disabled", nfr, n0);
        check(adc_sclk === 1'b1, "R1 idle serial clock high", adc_sclk, 1);
        enable = 1;
        wait_frames(2);
        check(spacing == 42, "R10 spacing after re-enable", spacing, 42);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        while (cyc < 150000 && !done) @(posedge clk);
        if (!done) begin
            check(0, "watchdog expired", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule